// File: doc/BRIEF.md
# SPI Master FIFO Flag and Interrupt Unit

This unit sits beside the transmit and receive FIFOs of a FIFO-based SPI master and turns their fill levels and the serial engine's events into one status word, a per-bit interrupt enable word, and a pair of watermark thresholds that drive the two data-request flags. Six of the status bits follow the FIFO levels directly. The other two, receive overflow and transfer complete, are event flags that stay set until software writes a one to them. A driver can therefore read the status word and write the same value back to acknowledge exactly the events it has seen.

The unit also gates the shifter's received-word strobe. A word that arrives while the receive FIFO is full is not pushed, and the overflow flag is raised in its place. The single interrupt line is the OR of every status bit whose enable is set, and it passes through one register stage before it leaves the block.

Top module: `spi_flag_irq`

## Requirements
- R1: After reset the enable word, both thresholds and both event flags are zero, and `irq` is low.
- R2: Status bit 0 (transmit empty) is 1 exactly when `tx_level` is 0. Status bit 2 (transmit full) is 1 exactly when `tx_level` equals DEPTH. Both follow the level in the same cycle.
- R3: Status bit 1 (transmit data request) is 1 while `tx_level` is less than or equal to the transmit threshold, which is held in bits 5:0 of the word at offset 0x14.
- R4: Status bit 3 (receive ready) is 1 while `rx_level` is non-zero. Status bit 5 (receive full) is 1 exactly when `rx_level` equals DEPTH.
- R5: Status bit 4 (receive data request) is 1 while `rx_level` is strictly greater than the receive threshold, which is held in bits 21:16 of the word at offset 0x14.
- R6: `rx_accept` follows `rx_word_done` unless `rx_level` equals DEPTH. In that case the word is dropped and status bit 6 (receive overflow) is set from the next cycle on.
- R7: Status bit 7 (transfer complete) is set in the cycle after the condition "`tx_level` is 0 and `shifter_idle` is high" goes from false to true. A condition that is already true when reset releases does not set it.
- R8: A write to the status word at offset 0x18 clears bit 6 and/or bit 7 where the written data has a 1. Bits written as 0 keep their value, and the level-derived bits are unaffected.
- R9: If an event and a write-one-to-clear of the same flag fall in the same cycle, the flag is left set.
- R10: The enable word at offset 0x10 (bits 7:0) and the threshold word at offset 0x14 read back as written. Reserved threshold bits read as zero.
- R11: `irq` in cycle N+1 equals the OR over bits 7:0 of (status AND enable) in cycle N.
- R12: Reads of any other offset return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| tx_level | input | LVL_W (7) | Transmit FIFO fill level, 0..DEPTH |
| rx_level | input | LVL_W (7) | Receive FIFO fill level, 0..DEPTH |
| rx_word_done | input | 1 | Shifter has assembled one received word |
| shifter_idle | input | 1 | Shift register has finished its last burst |
| rx_accept | output | 1 | Push strobe to the receive FIFO |
| irq | output | 1 | Registered, level-sensitive interrupt |

## Verification
The bench sweeps every threshold against every FIFO level. An off-by-one in either comparison would show up as the transmit request failing to assert at the threshold itself, or the receive request asserting at the threshold when it should only assert above it. It runs all 256 enable patterns against a fixed status word, which catches an enable wired to the wrong bit or an interrupt taken without its register stage. For the event flags it targets four cases:
- a clear that coincides with a new event, where a design that lets the clear win loses the event;
- a clear with zero data bits, where a design that clears on any write drops the flag;
- a transfer-complete condition already present at reset, where a design without edge detection raises a false completion;
- a word arriving into a full FIFO, where a design that still pushes it corrupts the FIFO and gives no overflow.

// File: rtl/sfx_pkg.sv
// Package: shared constants for the SPI flag/interrupt unit.
// Holds register offsets, status bit positions and field placement.
// Assumes a 32-bit register bus with byte offsets.
package sfx_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned STS_W   = 8;
    localparam int unsigned THR_W   = 6;
    localparam int unsigned RXT_LSB = 16;

    localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_THRESH = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h18;

    localparam logic [REG_W-1:0] THR_KEEP = 32'h003F_003F;

    localparam int unsigned B_TX_EMPTY = 0;
    localparam int unsigned B_TX_REQ   = 1;
    localparam int unsigned B_TX_FULL  = 2;
    localparam int unsigned B_RX_RDY   = 3;
    localparam int unsigned B_RX_REQ   = 4;
    localparam int unsigned B_RX_FULL  = 5;
    localparam int unsigned B_RX_OVF   = 6;
    localparam int unsigned B_XFER_END = 7;

    // number of sticky event flags, located at the top of the status word
    localparam int unsigned N_EVT = 2;
endpackage

// File: rtl/sfx_regs.sv
// Module: register file for enables and thresholds, plus read mux.
// Decodes writes to the enable, threshold and status offsets; the status
// write is turned into a write-one-to-clear mask for the sticky flags.
// Assumes single-cycle writes and a combinational read path.
module sfx_regs
    import sfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [STS_W-1:0]  sts,
    output logic [STS_W-1:0]  en_q,
    output logic [THR_W-1:0]  tx_thr,
    output logic [THR_W-1:0]  rx_thr,
    output logic [N_EVT-1:0]  evt_clr,
    output logic [REG_W-1:0]  rdata
);
    logic [REG_W-1:0] thr_q;
    logic             hit_en, hit_thr, hit_sts;

    // address decode of the write strobe
    always_comb begin
        hit_en  = wr && (addr == OFF_ENABLE);
        hit_thr = wr && (addr == OFF_THRESH);
        hit_sts = wr && (addr == OFF_STATUS);
    end

    // enable word storage
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (hit_en) en_q <= wdata[STS_W-1:0];
    end

    // threshold word storage, reserved bits forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n)       thr_q <= '0;
        else if (hit_thr) thr_q <= wdata & THR_KEEP;
    end

    // threshold fields and write-one-to-clear mask
    always_comb begin
        tx_thr  = thr_q[THR_W-1:0];
        rx_thr  = thr_q[RXT_LSB +: THR_W];
        evt_clr = hit_sts ? wdata[STS_W-1 -: N_EVT] : '0;
    end

    // read data selection
    always_comb begin
        case (addr)
            OFF_ENABLE: rdata = {{(REG_W-STS_W){1'b0}}, en_q};
            OFF_THRESH: rdata = thr_q;
            OFF_STATUS: rdata = {{(REG_W-STS_W){1'b0}}, sts};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/sfx_level_flags.sv
// Module: level-derived FIFO flags.
// Produces empty/full/ready and the two watermark requests from the FIFO
// levels and thresholds, all combinationally. Assumes levels never exceed
// DEPTH.
module sfx_level_flags
    import sfx_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    output logic             tx_empty,
    output logic             tx_req,
    output logic             tx_full,
    output logic             rx_rdy,
    output logic             rx_req,
    output logic             rx_full
);
    localparam int unsigned CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [CMP_W-1:0] tx_l, rx_l, tx_t, rx_t;

    // widen operands so the comparisons line up for any DEPTH
    always_comb begin
        tx_l = CMP_W'(tx_level);
        rx_l = CMP_W'(rx_level);
        tx_t = CMP_W'(tx_thr);
        rx_t = CMP_W'(rx_thr);
    end

    // flag generation
    always_comb begin
        tx_empty = (tx_level == '0);
        tx_full  = (tx_level == FULL_LVL);
        tx_req   = (tx_l <= tx_t);
        rx_rdy   = (rx_level != '0);
        rx_full  = (rx_level == FULL_LVL);
        rx_req   = (rx_l > rx_t);
    end
endmodule

// File: rtl/sfx_events.sv
// Module: sticky event flags (receive overflow, transfer complete).
// Overflow is raised by a received word arriving at a full FIFO; transfer
// complete by the rising edge of "tx empty and shifter idle". Both hold
// until cleared by write-one-to-clear; a same-cycle event wins.
module sfx_events
    import sfx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_word_done,
    input  logic             rx_full,
    input  logic             tx_empty,
    input  logic             shifter_idle,
    input  logic [N_EVT-1:0] evt_clr,
    output logic             rx_accept,
    output logic [N_EVT-1:0] evt_q
);
    logic             done_now, done_prev;
    logic [N_EVT-1:0] evt_set;

    // push gating and event detection
    always_comb begin
        rx_accept  = rx_word_done && !rx_full;
        done_now   = tx_empty && shifter_idle;
        evt_set[0] = rx_word_done && rx_full;
        evt_set[1] = done_now && !done_prev;
    end

    // previous completion condition, reset high to suppress a reset-time edge
    always_ff @(posedge clk) begin
        if (!rst_n) done_prev <= 1'b1;
        else        done_prev <= done_now;
    end

    // one sticky cell per event
    for (genvar g = 0; g < N_EVT; g++) begin : g_evt
        always_ff @(posedge clk) begin
            if (!rst_n) evt_q[g] <= 1'b0;
            else        evt_q[g] <= (evt_q[g] && !evt_clr[g]) || evt_set[g];
        end
    end
endmodule

// File: rtl/sfx_irq.sv
// Module: masked interrupt reduction with one register stage.
// Assumes status and enable share bit positions.
module sfx_irq
    import sfx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] sts,
    input  logic [STS_W-1:0] en,
    output logic             irq
);
    // register the OR of enabled status bits
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(sts & en);
    end
endmodule

// File: rtl/spi_flag_irq.sv
// Module: top of the SPI FIFO flag and interrupt unit.
// Assembles the status word from level flags and sticky events, holds the
// enable and threshold registers, gates the receive push and drives the
// registered interrupt. Assumes DEPTH >= 1 and levels within 0..DEPTH.
module spi_flag_irq
    import sfx_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_word_done,
    input  logic              shifter_idle,
    output logic              rx_accept,
    output logic              irq
);
    logic [STS_W-1:0] sts_word, en_word;
    logic [THR_W-1:0] tx_thr, rx_thr;
    logic [N_EVT-1:0] evt_clr, evt_q;
    logic             f_tx_empty, f_tx_req, f_tx_full;
    logic             f_rx_rdy, f_rx_req, f_rx_full;

    sfx_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .sts     (sts_word),
        .en_q    (en_word),
        .tx_thr  (tx_thr),
        .rx_thr  (rx_thr),
        .evt_clr (evt_clr),
        .rdata   (reg_rdata)
    );

    sfx_level_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_lvl (
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_thr   (tx_thr),
        .rx_thr   (rx_thr),
        .tx_empty (f_tx_empty),
        .tx_req   (f_tx_req),
        .tx_full  (f_tx_full),
        .rx_rdy   (f_rx_rdy),
        .rx_req   (f_rx_req),
        .rx_full  (f_rx_full)
    );

    sfx_events u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_word_done (rx_word_done),
        .rx_full      (f_rx_full),
        .tx_empty     (f_tx_empty),
        .shifter_idle (shifter_idle),
        .evt_clr      (evt_clr),
        .rx_accept    (rx_accept),
        .evt_q        (evt_q)
    );

    // status word assembly at the fixed bit positions
    always_comb begin
        sts_word             = '0;
        sts_word[B_TX_EMPTY] = f_tx_empty;
        sts_word[B_TX_REQ]   = f_tx_req;
        sts_word[B_TX_FULL]  = f_tx_full;
        sts_word[B_RX_RDY]   = f_rx_rdy;
        sts_word[B_RX_REQ]   = f_rx_req;
        sts_word[B_RX_FULL]  = f_rx_full;
        sts_word[B_RX_OVF]   = evt_q[0];
        sts_word[B_XFER_END] = evt_q[1];
    end

    sfx_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .sts   (sts_word),
        .en    (en_word),
        .irq   (irq)
    );
endmodule

// File: rtl/spi_flag_irq_chk.sv
// Module: property checker for spi_flag_irq, bound to every instance.
module spi_flag_irq_chk
    import sfx_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [LVL_W-1:0]  tx_level,
    input logic [LVL_W-1:0]  rx_level,
    input logic              rx_word_done,
    input logic              shifter_idle,
    input logic              rx_accept,
    input logic              irq,
    input logic [STS_W-1:0]  sts_word,
    input logic [STS_W-1:0]  en_word
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == FULL_LVL) |-> !rx_accept);

    // R6
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_done && rx_level == FULL_LVL) |=> sts_word[B_RX_OVF]);

    // R8
    overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_word[B_RX_OVF] && !(reg_wr && reg_addr == OFF_STATUS && reg_wdata[B_RX_OVF]))
        |=> sts_word[B_RX_OVF]);

    // R8
    complete_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_STATUS && reg_wdata[B_XFER_END]
         && !(tx_level == '0 && shifter_idle))
        |=> !sts_word[B_XFER_END]);

    // R11
    irq_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(sts_word & en_word))));
endmodule

bind spi_flag_irq spi_flag_irq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_flag_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .tx_level     (tx_level),
    .rx_level     (rx_level),
    .rx_word_done (rx_word_done),
    .shifter_idle (shifter_idle),
    .rx_accept    (rx_accept),
    .irq          (irq),
    .sts_word     (sts_word),
    .en_word      (en_word)
);

// File: tb/spi_flag_irq_bench.sv
module spi_flag_irq_bench;
    localparam int DEPTH = 64;
    localparam int LVL_W = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [LVL_W-1:0] tx_level = '0;
    logic [LVL_W-1:0] rx_level = '0;
    logic        rx_word_done = 1'b0;
    logic        shifter_idle = 1'b1;
    logic        rx_accept;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    spi_flag_irq #(.DEPTH(DEPTH)) u_spi_flag_irq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level),
        .rx_level(rx_level), .rx_word_done(rx_word_done),
        .shifter_idle(shifter_idle), .rx_accept(rx_accept), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write at a falling edge, one rising edge in between
    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] exp_lvl(input int tx, input int rx, input int tt, input int rt);
        logic [7:0] s;
        s = '0;
        s[0] = (tx == 0);
        s[1] = (tx <= tt);
        s[2] = (tx == DEPTH);
        s[3] = (rx != 0);
        s[4] = (rx > rt);
        s[5] = (rx == DEPTH);
        return s;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, R7: condition true at reset gives no completion
        rd_reg(8'h10, d); chk("R1 enable", d, 32'h0);
        rd_reg(8'h14, d); chk("R1 threshold", d, 32'h0);
        rd_reg(8'h18, d); chk("R1/R7 status", d, {24'h0, exp_lvl(0, 0, 0, 0)});
        chk("R1 irq", irq, 0);

        // R10: readback, reserved bits zero
        wr_reg(8'h14, 32'hFFFF_FFFF);
        rd_reg(8'h14, d); chk("R10 thresh readback", d, 32'h003F_003F);
        wr_reg(8'h10, 32'hFFFF_FFA5);
        rd_reg(8'h10, d); chk("R10 enable readback", d, 32'h0000_00A5);
        // R12: unmapped offsets
        wr_reg(8'h1C, 32'hFFFF_FFFF);
        wr_reg(8'h0C, 32'h0000_0000);
        rd_reg(8'h1C, d); chk("R12 unmapped read", d, 32'h0);
        rd_reg(8'h10, d); chk("R12 enable untouched", d, 32'h0000_00A5);
        rd_reg(8'h14, d); chk("R12 thresh untouched", d, 32'h003F_003F);
        wr_reg(8'h10, 32'h0);

        // R2 R3: transmit level sweep against every threshold
        for (int t = 0; t < 64; t++) begin
            wr_reg(8'h14, t);
            for (int l = 0; l <= DEPTH; l++) begin
                tx_level = l[LVL_W-1:0];
                rd_reg(8'h18, d);
                chk("R2/R3 tx flags", d[2:0], {29'h0, exp_lvl(l, 0, t, 0)} & 32'h7);
            end
        end
        tx_level = 5;

        // R4 R5: receive level sweep against every threshold
        for (int t = 0; t < 64; t++) begin
            wr_reg(8'h14, t << 16);
            for (int l = 0; l <= DEPTH; l++) begin
                rx_level = l[LVL_W-1:0];
                rd_reg(8'h18, d);
                chk("R4/R5 rx flags", {26'h0, d[5:3], 3'h0}, {24'h0, exp_lvl(5, l, 0, t) & 8'h38});
            end
        end

        // R6: accept pass-through below full
        rx_level = 10; rx_word_done = 1'b1; #1;
        chk("R6 accept", rx_accept, 1);
        @(negedge clk);
        rd_reg(8'h18, d); chk("R6 no overflow below full", d[6], 0);
        // R6: word at full is dropped and flagged
        rx_level = DEPTH; #1;
        chk("R6 drop at full", rx_accept, 0);
        @(negedge clk);
        rx_word_done = 1'b0;
        rd_reg(8'h18, d); chk("R6 overflow set", d[6], 1);
        // R8: zero write leaves, one write clears
        wr_reg(8'h18, 32'h0000_003F);
        rd_reg(8'h18, d); chk("R8 zero bit keeps", d[6], 1);
        wr_reg(8'h18, 32'h0000_0040);
        rd_reg(8'h18, d); chk("R8 one bit clears", d[6], 0);
        chk("R8 level bits kept", d[5:0], exp_lvl(5, DEPTH, 0, 0) & 8'h3F);
        // R9: overflow event with clear in same cycle
        rx_word_done = 1'b1;
        wr_reg(8'h18, 32'h0000_0040);
        rx_word_done = 1'b0;
        rd_reg(8'h18, d); chk("R9 set wins overflow", d[6], 1);
        wr_reg(8'h18, 32'h0000_0040);

        // R7: completion edge
        tx_level = 3; shifter_idle = 1'b1;
        @(negedge clk);
        tx_level = 0; #1;
        rd_reg(8'h18, d); chk("R7 not yet", d[7], 0);
        @(negedge clk);
        rd_reg(8'h18, d); chk("R7 set on edge", d[7], 1);
        wr_reg(8'h18, 32'h0000_0080);
        rd_reg(8'h18, d); chk("R7/R8 cleared, no re-fire", d[7], 0);
        @(negedge clk);
        rd_reg(8'h18, d); chk("R7 stays clear", d[7], 0);
        // R9: completion event with clear in same cycle
        shifter_idle = 1'b0;
        @(negedge clk);
        shifter_idle = 1'b1;
        wr_reg(8'h18, 32'h0000_0080);
        rd_reg(8'h18, d); chk("R9 set wins complete", d[7], 1);
        wr_reg(8'h18, 32'h0000_0080);

        // R11: enable sweep; status fixed at 0x3B (tx 0, rx full, thr 0)
        wr_reg(8'h14, 32'h0);
        rx_level = DEPTH; tx_level = 0;
        for (int e = 0; e < 256; e++) begin
            wr_reg(8'h10, e);
            @(negedge clk);
            chk("R11 irq mask", irq, |(e[7:0] & 8'h3B));
        end
        // R11: one-cycle register stage
        wr_reg(8'h10, 32'h08);
        rx_level = 0;
        @(negedge clk);
        chk("R11 irq low", irq, 0);
        rx_level = 1; #1;
        chk("R11 not combinational", irq, 0);
        @(negedge clk);
        chk("R11 irq after stage", irq, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule